// File: doc/BRIEF.md
# Firmware Hub Write Target

This block is the device side of a write transaction on a 4-bit multiplexed firmware-hub bus. It watches an active-low frame strobe and a nibble bus. When it sees a start code it checks the following nibble against a strapped 4-bit device ID. It then collects a 28-bit address, a size nibble and one data byte. Once the host has turned the bus around, the block drives the sync and turnaround nibbles. The bus is modelled as separate input, output and output-enable signals. The pad or tri-state logic is built outside the block.

An accepted write leaves the block as a single-cycle strobe, with the full address and data byte held steady beside it. A write buffer or the flash command logic takes the strobe from there. A transaction is ignored silently when the ID does not match or the size is anything but one byte. In both cases the output driver stays off.

Clock numbering below counts the clock that carries the last start nibble as cycle 1. A frame then ends at cycle 17.

Top module: `fwh_write_target`

## Requirements
- R1: While `rstN` is low, the state is cleared on every clock edge. In the cycle after such an edge, `busOe` and `wrStrobe` are both low.
- R2: A transaction begins only on a clock edge where `frameN` is low and `busIn` is 4'b1110. Any other nibble seen with `frameN` low begins nothing.
- R3: While `frameN` stays low, only the nibble of the last low cycle counts. If start nibbles are followed by a different nibble before `frameN` rises, there is no transaction.
- R4: The nibble in cycle 2, taken with `frameN` high, must equal `devId`. If it differs, the block never drives the bus and never strobes for that frame.
- R5: Cycles 3 to 9 carry the 28-bit address, most significant nibble first. In cycle 3, `busIn` gives address bits 27:24, and in cycle 9 it gives bits 3:0.
- R6: The size nibble in cycle 10 must be 4'b0000. Any other value abandons the frame with no drive and no strobe.
- R7: Cycle 11 carries data bits 3:0 and cycle 12 carries data bits 7:4.
- R8: In cycle 15 of an accepted frame, `busOe` is high and `busOut` is 4'b0000.
- R9: In cycle 16 of an accepted frame, `busOe` is high and `busOut` is 4'b1111. From cycle 17 on, `busOe` is low. `busOe` is also low in cycles 1 to 14.
- R10: `wrStrobe` is high for exactly one cycle, which is cycle 15 of an accepted frame. In that cycle `wrAddr` and `wrData` carry the collected address and data.
- R11: If `frameN` is low on an edge after cycle 2 of a frame, the frame is abandoned. If that nibble is 4'b1110, it counts as cycle 1 of a new frame.
- R12: A new start can be taken in the cycle straight after cycle 17 of the previous frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| frameN | input | 1 | Frame strobe, active low |
| busIn | input | 4 | Nibble seen on the bus |
| devId | input | 4 | Strapped device ID |
| busOut | output | 4 | Nibble the block drives |
| busOe | output | 1 | Output enable for `busOut` |
| wrStrobe | output | 1 | One-cycle write strobe |
| wrAddr | output | 28 | Address of the accepted write |
| wrData | output | 8 | Data byte of the accepted write |

## Verification
Frames are sent with random ID, address, data and size values. The ID is made to match half the time, and the size is mostly one byte. Each frame also carries one to three start nibbles and a random idle gap. This separates an accepted frame from one rejected by the ID check or the size check, and it catches nibble-order mistakes in the address and the data. Directed frames cover the remaining cases:
- a low frame strobe whose final nibble is not a start
- an abort in the address phase that restarts at once
- an abort during the host turnaround
- all-ones and all-zero address and data values
- back-to-back frames with no gap

These show apart last-start-wins framing, restart on abort, and bit-position errors at the edges of the fields.

// File: rtl/fwh_pkg.sv
package fwh_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_START,
    ST_ADDR,
    ST_SIZE,
    ST_DLO,
    ST_DHI,
    ST_HTAR,
    ST_TTAR,
    ST_SYNC,
    ST_TONES,
    ST_FLOAT
  } fwhState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic shiftAddr;
    logic loadLo;
    logic loadHi;
    logic driveSync;
    logic driveOnes;
  } fwhCtl_t;

endpackage

// File: rtl/fwh_ctrl.sv
module fwh_ctrl
  import fwh_pkg::*;
#(
  parameter int NIB_W      = 4,
  parameter int ADDR_NIBS  = 7,
  parameter logic [NIB_W-1:0] START_CODE = 4'hE,
  parameter logic [NIB_W-1:0] SIZE_ONE   = 4'h0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameN,
  input  logic [NIB_W-1:0] busIn,
  input  logic [NIB_W-1:0] devId,
  output fwhCtl_t          ctl,
  output logic             wrStrobe
);

  localparam int CNT_W = (ADDR_NIBS > 1) ? $clog2(ADDR_NIBS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_NIBS - 1);

  fwhState_t state, nxt;
  logic [CNT_W-1:0] nibCnt;
  logic abortNow;

  assign abortNow = !frameN && (state != ST_IDLE) && (state != ST_START);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (!frameN && busIn == START_CODE) nxt = ST_START;
      ST_START: begin
        if (!frameN)             nxt = (busIn == START_CODE) ? ST_START : ST_IDLE;
        else if (busIn == devId) nxt = ST_ADDR;
        else                     nxt = ST_IDLE;
      end
      ST_ADDR:  if (nibCnt == CNT_LAST) nxt = ST_SIZE;
      ST_SIZE:  nxt = (busIn == SIZE_ONE) ? ST_DLO : ST_IDLE;
      ST_DLO:   nxt = ST_DHI;
      ST_DHI:   nxt = ST_HTAR;
      ST_HTAR:  nxt = ST_TTAR;
      ST_TTAR:  nxt = ST_SYNC;
      ST_SYNC:  nxt = ST_TONES;
      ST_TONES: nxt = ST_FLOAT;
      ST_FLOAT: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (abortNow) nxt = (busIn == START_CODE) ? ST_START : ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      nibCnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_ADDR && frameN) nibCnt <= nibCnt + 1'b1;
      else                            nibCnt <= '0;
    end
  end

  always_comb begin
    ctl.shiftAddr = (state == ST_ADDR) && frameN;
    ctl.loadLo    = (state == ST_DLO)  && frameN;
    ctl.loadHi    = (state == ST_DHI)  && frameN;
    ctl.driveSync = (state == ST_SYNC);
    ctl.driveOnes = (state == ST_TONES);
  end

  assign wrStrobe = (state == ST_SYNC);

endmodule

// File: rtl/fwh_dpath.sv
module fwh_dpath
  import fwh_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NIB_W-1:0]           busIn,
  input  fwhCtl_t                    ctl,
  output logic [NIB_W-1:0]           busOut,
  output logic                       busOe,
  output logic [NIB_W*ADDR_NIBS-1:0] wrAddr,
  output logic [2*NIB_W-1:0]         wrData
);

  localparam int ADDR_W = NIB_W * ADDR_NIBS;

  logic [ADDR_W-1:0]  addrReg;
  logic [2*NIB_W-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
    end else begin
      if (ctl.shiftAddr) addrReg <= {addrReg[ADDR_W-NIB_W-1:0], busIn};
      if (ctl.loadLo)    dataReg[NIB_W-1:0]       <= busIn;
      if (ctl.loadHi)    dataReg[2*NIB_W-1:NIB_W] <= busIn;
    end
  end

  assign busOe  = ctl.driveSync | ctl.driveOnes;
  assign busOut = ctl.driveOnes ? '1 : '0;
  assign wrAddr = addrReg;
  assign wrData = dataReg;

endmodule

// File: rtl/fwh_write_target.sv
module fwh_write_target
  import fwh_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 7
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameN,
  input  logic [NIB_W-1:0]           busIn,
  input  logic [NIB_W-1:0]           devId,
  output logic [NIB_W-1:0]           busOut,
  output logic                       busOe,
  output logic                       wrStrobe,
  output logic [NIB_W*ADDR_NIBS-1:0] wrAddr,
  output logic [2*NIB_W-1:0]         wrData
);

  fwhCtl_t ctl;

  fwh_ctrl #(.NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .busIn(busIn), .devId(devId),
    .ctl(ctl), .wrStrobe(wrStrobe)
  );

  fwh_dpath #(.NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS)) dpath_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .ctl(ctl),
    .busOut(busOut), .busOe(busOe), .wrAddr(wrAddr), .wrData(wrData)
  );

endmodule

// File: rtl/fwh_write_target_chk.sv
module fwh_write_target_chk #(
  parameter int NIB_W     = 4,
  parameter int ADDR_NIBS = 7
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       frameN,
  input logic [NIB_W-1:0]           busOut,
  input logic                       busOe,
  input logic                       wrStrobe,
  input logic [NIB_W*ADDR_NIBS-1:0] wrAddr,
  input logic [2*NIB_W-1:0]         wrData
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rstN |=> !busOe && !wrStrobe); // R1
  AST_SYNC_WITH_STROBE: assert property (@(posedge clk) disable iff (!rstN) wrStrobe |-> busOe && busOut == '0); // R8
  AST_ONES_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rstN) wrStrobe && frameN |=> busOe && busOut == '1); // R9
  AST_RELEASE_AFTER_ONES: assert property (@(posedge clk) disable iff (!rstN) busOe && busOut == '1 |=> !busOe); // R9
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) wrStrobe |=> !wrStrobe); // R10
  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rstN) wrStrobe |-> $stable(wrAddr) && $stable(wrData)); // R10

endmodule

bind fwh_write_target fwh_write_target_chk #(.NIB_W(NIB_W), .ADDR_NIBS(ADDR_NIBS)) chk_i (
  .clk(clk), .rstN(rstN), .frameN(frameN), .busOut(busOut), .busOe(busOe),
  .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
);

// File: tb/fwh_write_target_tb_top.sv
`timescale 1ns/1ps
module fwh_write_target_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameN = 1'b1;
  logic [3:0] busIn = 4'hF;
  logic [3:0] devId = 4'hA;
  wire  [3:0] busOut;
  wire        busOe, wrStrobe;
  wire [27:0] wrAddr;
  wire  [7:0] wrData;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fwh_write_target dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .busIn(busIn), .devId(devId),
    .busOut(busOut), .busOe(busOe), .wrStrobe(wrStrobe), .wrAddr(wrAddr), .wrData(wrData)
  );

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expectAccept(logic [3:0] id, logic [3:0] dev, logic [3:0] size, bit badLast);
    return !badLast && id == dev && size == 4'h0;
  endfunction

  function automatic logic [3:0] fieldNib(int k, logic [3:0] id, logic [27:0] addr,
                                          logic [3:0] size, logic [7:0] data);
    if (k == 2) return id;
    if (k >= 3 && k <= 9) return addr[(9-k)*4 +: 4];  // R5 most significant first
    if (k == 10) return size;
    if (k == 11) return data[3:0];                      // R7 low nibble first
    if (k == 12) return data[7:4];
    return 4'hF;
  endfunction

  // Outputs are sampled at the falling edge inside cycle k, then field k is driven.
  task automatic sendFrame(logic [3:0] id, logic [27:0] addr, logic [7:0] data, logic [3:0] size,
                           int nStarts, bit badLast, bit skipStart, int abortAt);
    bit acc;
    acc = expectAccept(id, devId, size, badLast);
    for (int i = 1; i < nStarts; i++) begin
      @(negedge clk);
      chk(!busOe && !wrStrobe, "R3 quiet during repeated start", {busOe, wrStrobe}, 0);
      frameN = 1'b0;
      busIn  = 4'hE;
    end
    for (int k = (skipStart ? 2 : 1); k <= 17; k++) begin
      @(negedge clk);
      if (acc && k == 15) begin
        chk(busOe && busOut == 4'h0, "R8 sync nibble", {busOe, busOut}, 5'h10);
        chk(wrStrobe, "R10 strobe at sync", wrStrobe, 1);
        chk(wrAddr == addr, "R5 address", wrAddr, addr);
        chk(wrData == data, "R7 data", wrData, data);
      end else if (acc && k == 16) begin
        chk(busOe && busOut == 4'hF && !wrStrobe, "R9 ones after sync",
            {wrStrobe, busOe, busOut}, 6'h1F);
      end else if (acc) begin
        chk(!busOe && !wrStrobe, "R9 bus released", {busOe, wrStrobe}, 0);
      end else begin
        chk(!busOe && !wrStrobe, "R4 R6 R3 R2 no response", {busOe, wrStrobe}, 0);
      end
      if (k == abortAt) begin
        frameN = 1'b0;   // R11 restart with a new start nibble
        busIn  = 4'hE;
        return;
      end
      if (k == 1) begin
        frameN = 1'b0;
        busIn  = badLast ? 4'h5 : 4'hE;
      end else begin
        frameN = 1'b1;
        busIn  = fieldNib(k, id, addr, size, data);
      end
    end
  endtask

  task automatic idleGap(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!busOe && !wrStrobe, "R2 idle quiet", {busOe, wrStrobe}, 0);
      frameN = 1'b1;
      busIn  = 4'hF;
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1 reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (i > 0) chk(!busOe && !wrStrobe, "R1 reset state", {busOe, wrStrobe}, 0);
    end
    rstN = 1'b1;
    idleGap(2);

    devId = 4'hA;
    sendFrame(4'hA, 28'h1234567, 8'hC3, 4'h0, 1, 0, 0, 0);        // R5 R7 R8
    sendFrame(4'hA, 28'hFEDCBA9, 8'h5A, 4'h0, 3, 0, 0, 0);        // R12 back to back, R3 repeated starts
    idleGap(1);
    sendFrame(4'h5, 28'h0000001, 8'h01, 4'h0, 1, 0, 0, 0);        // R4 mismatch
    sendFrame(4'hA, 28'h0000002, 8'h02, 4'h1, 1, 0, 0, 0);        // R6 bad size
    sendFrame(4'hA, 28'h0000003, 8'h03, 4'h0, 2, 1, 0, 0);        // R3 last nibble not start
    sendFrame(4'hA, 28'h0000004, 8'h04, 4'h0, 1, 1, 0, 0);        // R2 non-start with strobe low
    sendFrame(4'hA, 28'h0ABCDEF, 8'h11, 4'h0, 1, 0, 0, 6);        // R11 abort in address
    sendFrame(4'hA, 28'h7654321, 8'h99, 4'h0, 1, 0, 1, 0);
    sendFrame(4'hA, 28'h1111111, 8'h22, 4'h0, 1, 0, 0, 14);       // R11 abort in turnaround
    sendFrame(4'hA, 28'hFFFFFFF, 8'hFF, 4'h0, 1, 0, 1, 0);
    sendFrame(4'hA, 28'h0000000, 8'h00, 4'h0, 1, 0, 0, 0);

    for (int n = 0; n < 60; n++) begin
      logic [3:0] id, size;
      logic [27:0] addr;
      logic [7:0] data;
      devId = 4'($urandom);
      id    = ($urandom % 2 == 0) ? devId : 4'($urandom);
      size  = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      addr  = 28'($urandom);
      data  = 8'($urandom);
      sendFrame(id, addr, data, size, 1 + int'($urandom % 3), ($urandom % 8 == 0), 0, 0);
      idleGap(int'($urandom % 3));
    end
    idleGap(2);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2ms;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule